// File: doc/BRIEF.md
# Dithered Second-Order Sigma-Delta Divide-Ratio Modulator

This block produces the per-reference-cycle divide ratio for the feedback divider of a fractional-N frequency synthesizer. The block runs on the reference clock and advances once on each edge. Its inputs are an integer divide value and an unsigned 16-bit fraction. Each cycle it emits a small signed correction and the corrected divide ratio, which is the integer value plus the correction, clamped to the legal divider range.

The fraction first passes through a two-tap averaging prefilter, (1 + z^-1)/2. This places a zero at half the reference rate and keeps one extra bit of precision, so the DC gain is exactly one. The filtered value then enters a second-order error-feedback loop, whose noise transfer function is (1 - z^-1)^2 and whose signal gain is one. A 23-bit maximal-length LFSR can add one fractional LSB on cycles where its output bit is set. This breaks up the periodic patterns that would otherwise leave tones at alpha and 1 - alpha of the reference frequency. An enable input turns the dither off.

Top module: `sd2_divmod`

## Requirements
- R1: While `rst` is high, each clock edge clears the error history and the prefilter delay, sets `y_out` to 0 and `div_out` to `DIV_MIN` (4), and loads the LFSR with the nonzero seed 1.
- R2: One edge after the inputs are applied, `y_out` and `div_out` reflect those inputs, and both outputs update on every clock edge.
- R3: `y_out` is a 3-bit two's-complement value that always lies in the range -1 to +3, so the quantizer never clips.
- R4: With dither off and a constant fraction F, let k = 0 be the first edge after reset. After k + 1 outputs, the running sum of `y_out` differs from (2k+1)·F/2^17 by strictly less than 1. This is the signature of (1 - z^-1)^2 shaping with unity signal gain.
- R5: The prefilter weights the first sample after reset by one half. With F = 0xFFFF and dither off, the first four outputs are 0, 2, 0, 2.
- R6: With dither off, the sum of `y_out` over 2^16 cycles from reset equals F within ±1, so the mean matches the fraction within one LSB.
- R7: With `dither_en` high, the output sequence differs from the undithered one for the same fraction. The running-sum error then stays below 1 plus one fractional LSB for each elapsed cycle.
- R8: `div_out` equals `int_in` + `y_out` from the same edge, clamped to the range `DIV_MIN` (4) to `DIV_MAX` (255).
- R9: The LFSR state is never all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| dither_en | input | 1 | Enables LFSR dither |
| int_in | input | 8 | Integer divide value |
| frac_in | input | 16 | Unsigned fraction, in units of 2^-16 |
| y_out | output | 3 | Signed correction, two's complement |
| div_out | output | 8 | Clamped divide ratio |

## Verification
The clamp and the modulator's largest corrections can land in the same cycle. This happens when `int_in` sits at or next to either range limit while the modulator emits +2 or -1. The bench holds the fraction at 0xFFFF, which produces a steady 0/2 pattern, and sweeps `int_in` through all 256 values. On every cycle it compares `div_out` against the clamp of `int_in` plus the observed `y_out`. The shaping and dither checks judge running sums against sums computed arithmetically from the fraction.

// File: rtl/sd2_divmod.sv
module sd2_divmod #(
  parameter int FRAC_W   = 16,
  parameter int INT_W    = 8,
  parameter int OUT_W    = 3,
  parameter int LFSR_W   = 23,
  parameter int LFSR_TAP = 18,
  parameter int DIV_MIN  = 4,
  parameter int DIV_MAX  = 255,
  parameter int SEED     = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dither_en,
  input  logic [INT_W-1:0]        int_in,
  input  logic [FRAC_W-1:0]       frac_in,
  output logic signed [OUT_W-1:0] y_out,
  output logic [INT_W-1:0]        div_out
);
  localparam int PW   = FRAC_W + 1;
  localparam int AW   = PW + 4;
  localparam int SW   = INT_W + 2;
  localparam int HALF = 1 << FRAC_W;

  logic [FRAC_W-1:0]       frac_d;
  logic [LFSR_W-1:0]       lfsr;
  logic                    dith;
  logic signed [AW-1:0]    e1, e2, x, v, yw, e;
  logic signed [OUT_W-1:0] y;
  logic signed [SW-1:0]    sum;
  logic [INT_W-1:0]        div_n;

  assign dith = dither_en & lfsr[0];
  assign x  = $signed({{(AW-FRAC_W){1'b0}}, frac_in})
            + $signed({{(AW-FRAC_W){1'b0}}, frac_d})
            + $signed({{(AW-2){1'b0}}, dith, 1'b0});
  assign v  = x + (e1 <<< 1) - e2;
  assign yw = (v + AW'(HALF)) >>> PW;
  assign e  = v - (yw <<< PW);
  assign y  = yw[OUT_W-1:0];

  assign sum = $signed({2'b00, int_in}) + $signed({{(SW-OUT_W){y[OUT_W-1]}}, y});

  always_comb begin
    if (sum < DIV_MIN)      div_n = INT_W'(DIV_MIN);
    else if (sum > DIV_MAX) div_n = INT_W'(DIV_MAX);
    else                    div_n = sum[INT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_d  <= '0;
      e1      <= '0;
      e2      <= '0;
      lfsr    <= LFSR_W'(SEED);
      y_out   <= '0;
      div_out <= INT_W'(DIV_MIN);
    end else begin
      frac_d  <= frac_in;
      e1      <= e;
      e2      <= e1;
      lfsr    <= {lfsr[LFSR_W-2:0], lfsr[LFSR_W-1] ^ lfsr[LFSR_TAP-1]};
      y_out   <= y;
      div_out <= div_n;
    end
  end
endmodule

// File: rtl/sd2_divmod_chk.sv
module sd2_divmod_chk #(
  parameter int OUT_W   = 3,
  parameter int INT_W   = 8,
  parameter int LFSR_W  = 23,
  parameter int DIV_MIN = 4,
  parameter int DIV_MAX = 255
) (
  input logic                    clk,
  input logic                    rst,
  input logic signed [OUT_W-1:0] y_out,
  input logic [INT_W-1:0]        div_out,
  input logic [LFSR_W-1:0]       lfsr
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (y_out == 0 && div_out == INT_W'(DIV_MIN)));

  assert_out_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (y_out >= -1 && y_out <= 3));

  assert_div_range_R8: assert property (@(posedge clk) disable iff (rst)
    (div_out >= INT_W'(DIV_MIN) && div_out <= INT_W'(DIV_MAX)));

  assert_lfsr_live_R9: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);
endmodule

bind sd2_divmod sd2_divmod_chk #(
  .OUT_W(OUT_W), .INT_W(INT_W), .LFSR_W(LFSR_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
) chk_i (
  .clk(clk), .rst(rst), .y_out(y_out), .div_out(div_out), .lfsr(lfsr)
);

// File: tb/sd2_divmod_tb_top.sv
module sd2_divmod_tb_top;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              dither_en = 1'b0;
  logic [7:0]        int_in = 8'd0;
  logic [15:0]       frac_in = 16'd0;
  logic signed [2:0] y_out;
  logic [7:0]        div_out;

  int checks = 0;
  int fails = 0;
  logic signed [2:0] ref_seq [4000];

  always #4 clk = ~clk;

  sd2_divmod dut_i (
    .clk(clk), .rst(rst), .dither_en(dither_en),
    .int_in(int_in), .frac_in(frac_in), .y_out(y_out), .div_out(div_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [15:0] f, input logic [7:0] i, input logic d);
    @(negedge clk);
    rst = 1'b1; frac_in = f; int_in = i; dither_en = d;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_sum(input logic [15:0] f, input int n, input logic d,
                         input bit avg, input bit store, input bit cmp);
    longint ysum = 0;
    longint diff;
    longint slack;
    bit bad = 0;
    longint bad_act = 0, bad_exp = 0;
    int differ = 0;
    start(f, 8'd100, d);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ysum += y_out;
      diff = ysum * 131072 - (2 * longint'(k) + 1) * f;
      slack = d ? 2 * (longint'(k) + 1) : 0;
      if (!bad && (diff >= 131072 + slack || diff <= -131072 - slack)) begin
        bad = 1; bad_act = ysum * 131072; bad_exp = (2 * longint'(k) + 1) * f;
      end
      if (store) ref_seq[k] = y_out;
      if (cmp && ref_seq[k] != y_out) differ++;
    end
    check(!bad, d ? "R7 dithered running sum" : "R4 shaped running sum", bad_act, bad_exp);
    if (avg) check(ysum - f <= 1 && f - ysum <= 1, "R6 mean over 2^16", ysum, f);
    if (cmp) check(differ > 0, "R7 dither alters sequence", differ, 1);
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    int_in = 8'd77; frac_in = 16'hFFFF;
    @(negedge clk);
    check(y_out == 0, "R1 y_out in reset", y_out, 0);
    check(div_out == 8'd4, "R1 div_out in reset", div_out, 4);

    // R2, R5: prefilter half weight on first sample
    start(16'hFFFF, 8'd100, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(y_out == ((k % 2) ? 2 : 0), "R5 prefilter start pattern", y_out, (k % 2) ? 2 : 0);
      check(div_out == 8'(100 + ((k % 2) ? 2 : 0)), "R2 registered ratio", div_out, 100 + ((k % 2) ? 2 : 0));
    end

    // R4: zero fraction gives zero correction
    start(16'h0000, 8'd50, 1'b0);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (k % 16 == 0) check(y_out == 0 && div_out == 8'd50, "R4 zero fraction", y_out, 0);
    end

    // R4, R3: sweep of fractions
    for (int i = 0; i < 64; i++)
      run_sum((i == 63) ? 16'hFFFF : 16'(i * 1040), 256, 1'b0, 1'b0, 1'b0, 1'b0);

    // R6: long averages
    run_sum(16'h5A3C, 65536, 1'b0, 1'b1, 1'b0, 1'b0);
    run_sum(16'h0007, 65536, 1'b0, 1'b1, 1'b0, 1'b0);

    // R7: dither effect
    run_sum(16'h4000, 4000, 1'b0, 1'b0, 1'b1, 1'b0);
    run_sum(16'h4000, 4000, 1'b1, 1'b0, 1'b0, 1'b1);

    // R8: clamp and correction coinciding, all integer values
    start(16'hFFFF, 8'd0, 1'b0);
    for (int i = 0; i < 256; i++) begin
      int_in = 8'(i);
      for (int c = 0; c < 4; c++) begin
        int s;
        int exp_div;
        @(negedge clk);
        s = i + int'(y_out);
        exp_div = (s < 4) ? 4 : (s > 255) ? 255 : s;
        check(int'(div_out) == exp_div, "R8 clamped ratio", div_out, exp_div);
        check(y_out >= -1 && y_out <= 3, "R3 correction range", y_out, 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule